// File: doc/BRIEF.md
# Merging Load Miss Queue

This block keeps track of the first-level data cache loads that missed in a multithreaded core. Each outstanding miss occupies a slot that holds the line address, a flag for a synchronized (reserving) load, a flag that records whether its downstream request has been accepted, and a bitmap of the threads waiting for that line. When a new miss arrives, its line address is compared against every occupied slot in the same cycle. On a match the requesting thread joins the slot's bitmap and no further traffic is generated. Without a match a free slot is claimed.

Each slot issues one fill request to the next memory level. Requests are chosen round robin among slots whose request has not yet been accepted. A fill response names the slot it completes, so responses may return in any order. On a response, a one-cycle wake pulse goes to every thread in that slot's bitmap and the slot is released. A synchronized load always occupies a slot of its own, so the lower level sees the reservation as a separate transaction.

Top module: `miss_merge_queue`

## Requirements
- R1: After reset, `full`, `fill_req_valid` and every bit of `wake_threads` are 0.
- R2: A miss that matches no occupied slot claims a free slot. On the clock edge after the claim, if no request is pending, `fill_req_valid` rises and carries the miss's line address, the slot number and the synchronized flag.
- R3: An ordinary miss whose line equals that of an occupied ordinary slot claims no slot and causes no additional fill request. The thread is added to that slot's bitmap.
- R4: A synchronized miss always claims a new slot and raises `fill_req_sync`. An ordinary miss never joins a slot that holds a synchronized load, and a synchronized miss never joins any slot.
- R5: While `fill_req_valid` is high and `fill_req_ack` is low, the request stays up and its line, slot and synchronized flag do not change. Once a request is acknowledged, that slot is never requested again.
- R6: Among slots with unaccepted requests, the next request goes to the first such slot after the most recently accepted slot number, counting upward and wrapping. After reset, slot 0 is the first in that order.
- R7: A fill response for slot s makes `wake_threads` equal to the slot's bitmap (bit t for thread t) for exactly one cycle, starting on the edge that takes the response. The slot becomes free on the same edge.
- R8: Responses may complete slots in any order. Each response wakes only the threads of the slot it names.
- R9: If an ordinary miss matches the slot receiving a fill response in the same cycle, the new thread's bit is included in that wake pulse and no slot is claimed.
- R10: `full` is high exactly when every slot is occupied.
- R11: A new slot is always the lowest-numbered free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A load miss is presented this cycle |
| miss_line | input | LINE_AW (26) | Line address of the miss |
| miss_tid | input | log2(THREADS) (2) | Thread that missed |
| miss_sync | input | 1 | Miss is a synchronized load |
| fill_req_valid | output | 1 | Fill request to the next level is pending |
| fill_req_line | output | LINE_AW (26) | Line address requested |
| fill_req_slot | output | log2(THREADS) (2) | Slot number carried as request identifier |
| fill_req_sync | output | 1 | Request is a synchronized load |
| fill_req_ack | input | 1 | Next level accepts the pending request |
| fill_resp_valid | input | 1 | Fill response arrives this cycle |
| fill_resp_slot | input | log2(THREADS) (2) | Slot that the response completes |
| wake_threads | output | THREADS (4) | One-cycle wake pulse, one bit per thread |
| full | output | 1 | All slots occupied |

## Verification
The merge function is exercised with four patterns. Two threads missing on one line shows merge versus allocation. A synchronized and an ordinary load to the same line shows that reservations are kept separate while ordinary misses still merge. A response that coincides with a matching miss shows that the late thread is folded into the wake. Several distinct lines, with one slot freed and then reused, show round-robin ordering as distinct from fixed priority, because the reused low slot must wait behind a higher one. Responses are returned in reverse order, and every wake bitmap is compared with the set of threads the bench placed on that line.

// File: rtl/mmq_pkg.sv
package mmq_pkg;
  // per-slot control flags
  typedef struct packed {
    logic busy;
    logic sent;
    logic sync;
  } slot_flags_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mmq_lookup.sv
module mmq_lookup #(
  parameter int N  = 4,
  parameter int AW = 26,
  localparam int IW = mmq_pkg::idx_width(N)
) (
  input  logic [N-1:0]  live,
  input  logic [N-1:0]  sync_e,
  input  logic [AW-1:0] tags [N],
  input  logic [AW-1:0] key,
  input  logic          key_sync,
  output logic [N-1:0]  hit,
  output logic          hit_any,
  output logic [IW-1:0] hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = live[g] && !sync_e[g] && !key_sync && (tags[g] == key);
  end

  assign hit_any = |hit;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) hit_idx = IW'(i);
    end
  end
endmodule

// File: rtl/mmq_first_free.sv
module mmq_first_free #(
  parameter int N = 4,
  localparam int IW = mmq_pkg::idx_width(N)
) (
  input  logic [N-1:0]  busy,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mmq_rr_arb.sv
module mmq_rr_arb #(
  parameter int N = 4,
  localparam int IW = mmq_pkg::idx_width(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  int k;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    k     = 0;
    // walk from farthest to nearest so the nearest candidate wins
    for (int off = N; off >= 1; off--) begin
      k = (int'(last) + off) % N;
      if (req[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/miss_merge_queue.sv
module miss_merge_queue #(
  parameter int THREADS = 4,
  parameter int LINE_AW = 26,
  localparam int SLOTS = THREADS,
  localparam int SW    = mmq_pkg::idx_width(SLOTS),
  localparam int TW    = mmq_pkg::idx_width(THREADS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               miss_valid,
  input  logic [LINE_AW-1:0] miss_line,
  input  logic [TW-1:0]      miss_tid,
  input  logic               miss_sync,
  output logic               fill_req_valid,
  output logic [LINE_AW-1:0] fill_req_line,
  output logic [SW-1:0]      fill_req_slot,
  output logic               fill_req_sync,
  input  logic               fill_req_ack,
  input  logic               fill_resp_valid,
  input  logic [SW-1:0]      fill_resp_slot,
  output logic [THREADS-1:0] wake_threads,
  output logic               full
);
  import mmq_pkg::*;

  slot_flags_t        flags    [SLOTS];
  logic [LINE_AW-1:0] slot_line[SLOTS];
  logic [THREADS-1:0] slot_wait[SLOTS];
  logic [SW-1:0]      rr_last;

  logic [SLOTS-1:0] busy_v, sync_v, pend_v;
  for (genvar g = 0; g < SLOTS; g++) begin : g_vec
    assign busy_v[g] = flags[g].busy;
    assign sync_v[g] = flags[g].sync;
    assign pend_v[g] = flags[g].busy && !flags[g].sent;
  end

  logic [SLOTS-1:0] hit_vec;
  logic             hit_any;
  logic [SW-1:0]    hit_idx;
  logic             free_found;
  logic [SW-1:0]    free_idx;
  logic             pick_found;
  logic [SW-1:0]    pick_idx;

  mmq_lookup #(.N(SLOTS), .AW(LINE_AW)) u_lookup (
    .live(busy_v), .sync_e(sync_v), .tags(slot_line), .key(miss_line),
    .key_sync(miss_sync), .hit(hit_vec), .hit_any(hit_any), .hit_idx(hit_idx)
  );

  mmq_first_free #(.N(SLOTS)) u_free (
    .busy(busy_v), .found(free_found), .idx(free_idx)
  );

  mmq_rr_arb #(.N(SLOTS)) u_arb (
    .req(pend_v), .last(rr_last), .found(pick_found), .idx(pick_idx)
  );

  logic [THREADS-1:0] tid_bit;
  logic               do_merge, merge_into_fill, do_alloc;
  assign tid_bit         = THREADS'(1) << miss_tid;
  assign do_merge        = miss_valid && hit_any;
  assign merge_into_fill = do_merge && fill_resp_valid && (hit_idx == fill_resp_slot);
  assign do_alloc        = miss_valid && !hit_any && free_found;
  assign full            = &busy_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) begin
        flags[i]     <= '0;
        slot_line[i] <= '0;
        slot_wait[i] <= '0;
      end
      rr_last        <= SW'(SLOTS - 1);
      fill_req_valid <= 1'b0;
      fill_req_line  <= '0;
      fill_req_slot  <= '0;
      fill_req_sync  <= 1'b0;
      wake_threads   <= '0;
    end else begin
      // downstream request register
      if (fill_req_valid) begin
        if (fill_req_ack) begin
          fill_req_valid             <= 1'b0;
          flags[fill_req_slot].sent  <= 1'b1;
          rr_last                    <= fill_req_slot;
        end
      end else if (pick_found) begin
        fill_req_valid <= 1'b1;
        fill_req_line  <= slot_line[pick_idx];
        fill_req_slot  <= pick_idx;
        fill_req_sync  <= flags[pick_idx].sync;
      end

      // wake pulse
      if (fill_resp_valid)
        wake_threads <= slot_wait[fill_resp_slot] | (merge_into_fill ? tid_bit : '0);
      else
        wake_threads <= '0;

      if (do_merge && !merge_into_fill)
        slot_wait[hit_idx] <= slot_wait[hit_idx] | tid_bit;

      if (fill_resp_valid) begin
        flags[fill_resp_slot]     <= '0;
        slot_wait[fill_resp_slot] <= '0;
      end

      if (do_alloc) begin
        flags[free_idx].busy <= 1'b1;
        flags[free_idx].sent <= 1'b0;
        flags[free_idx].sync <= miss_sync;
        slot_line[free_idx]  <= miss_line;
        slot_wait[free_idx]  <= tid_bit;
      end
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fill_req_valid && !fill_req_ack |=> fill_req_valid && $stable(fill_req_line)
      && $stable(fill_req_slot) && $stable(fill_req_sync));

  // R3
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    miss_valid |-> $onehot0(hit_vec));

  // R2
  slot_grow_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(busy_v) > $past($countones(busy_v))) |-> $past(miss_valid && !hit_any));

  // R7
  fill_frees_chk: assert property (@(posedge clk) disable iff (rst)
    fill_resp_valid |=> !busy_v[$past(fill_resp_slot)]);

  // R7
  wake_src_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_threads != '0) |-> $past(fill_resp_valid));

  for (genvar g = 0; g < SLOTS; g++) begin : g_sync_chk
    // R4
    sync_alone_chk: assert property (@(posedge clk) disable iff (rst)
      busy_v[g] && sync_v[g] |-> $countones(slot_wait[g]) == 1);
  end
endmodule

// File: tb/miss_merge_queue_bench.sv
`timescale 1ns/1ps
module miss_merge_queue_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [25:0] miss_line = '0;
  logic [1:0]  miss_tid = '0;
  logic        miss_sync = 1'b0;
  logic        fill_req_valid;
  logic [25:0] fill_req_line;
  logic [1:0]  fill_req_slot;
  logic        fill_req_sync;
  logic        fill_req_ack = 1'b0;
  logic        fill_resp_valid = 1'b0;
  logic [1:0]  fill_resp_slot = '0;
  logic [3:0]  wake_threads;
  logic        full;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  miss_merge_queue u_miss_merge_queue (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_tid(miss_tid), .miss_sync(miss_sync), .fill_req_valid(fill_req_valid),
    .fill_req_line(fill_req_line), .fill_req_slot(fill_req_slot),
    .fill_req_sync(fill_req_sync), .fill_req_ack(fill_req_ack),
    .fill_resp_valid(fill_resp_valid), .fill_resp_slot(fill_resp_slot),
    .wake_threads(wake_threads), .full(full)
  );

  localparam logic [25:0] LA = 26'h0ABC123, LB = 26'h1000040, LC = 26'h0000011,
                          LD = 26'h0000022, LE = 26'h0000033, LG = 26'h0000044,
                          LH = 26'h2FFFFFF, LJ = 26'h0123456, LK = 26'h3FFFFFF;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic miss(input logic [25:0] a, input logic [1:0] t, input logic s);
    miss_valid = 1'b1; miss_line = a; miss_tid = t; miss_sync = s;
    step();
    miss_valid = 1'b0; miss_sync = 1'b0;
  endtask

  task automatic fill(input logic [1:0] s);
    fill_resp_valid = 1'b1; fill_resp_slot = s;
    step();
    fill_resp_valid = 1'b0;
  endtask

  task automatic serve(input string tag, input logic [1:0] s, input logic [25:0] a, input logic sy);
    for (int w = 0; w < 6 && !fill_req_valid; w++) step();
    chk({tag, " req valid"}, fill_req_valid, 1);
    chk({tag, " req slot"}, fill_req_slot, s);
    chk({tag, " req line"}, fill_req_line, a);
    chk({tag, " req sync"}, fill_req_sync, sy);
    fill_req_ack = 1'b1;
    step();
    fill_req_ack = 1'b0;
    chk({tag, " req drop after ack"}, fill_req_valid, 0);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 full", full, 0);
    chk("R1 req", fill_req_valid, 0);
    chk("R1 wake", wake_threads, 0);

    // R2 allocation timing, R11 lowest slot
    miss(LA, 2'd0, 1'b0);
    chk("R2 req not yet loaded", fill_req_valid, 0);
    step();
    chk("R2 req valid", fill_req_valid, 1);
    chk("R11 slot 0", fill_req_slot, 0);
    chk("R2 line", fill_req_line, LA);
    // R3 merge while request pending, R5 hold
    miss(LA, 2'd1, 1'b0);
    chk("R5 held valid", fill_req_valid, 1);
    chk("R5 held line", fill_req_line, LA);
    serve("R2", 2'd0, LA, 1'b0);
    step(); step();
    chk("R3 no second request", fill_req_valid, 0);
    chk("R3 one slot only", full, 0);
    fill(2'd0);
    chk("R3 R7 wake both", wake_threads, 4'b0011);
    step();
    chk("R7 one-cycle pulse", wake_threads, 0);

    // R4 sync isolation, R8 out-of-order fills
    miss(LB, 2'd2, 1'b0);
    miss(LB, 2'd3, 1'b1);
    miss(LB, 2'd0, 1'b0);
    miss(LB, 2'd1, 1'b1);
    serve("R4 ordinary", 2'd0, LB, 1'b0);
    serve("R4 sync a", 2'd1, LB, 1'b1);
    serve("R4 sync b", 2'd2, LB, 1'b1);
    chk("R10 three of four", full, 0);
    fill(2'd2);
    chk("R8 R4 wake slot2", wake_threads, 4'b0010);
    fill(2'd1);
    chk("R8 R4 wake slot1", wake_threads, 4'b1000);
    fill(2'd0);
    chk("R8 R4 wake slot0", wake_threads, 4'b0101);
    step();

    // R9 fill coinciding with matching miss
    miss(LH, 2'd0, 1'b0);
    serve("R9 setup", 2'd0, LH, 1'b0);
    fill_resp_valid = 1'b1; fill_resp_slot = 2'd0;
    miss_valid = 1'b1; miss_line = LH; miss_tid = 2'd1;
    step();
    fill_resp_valid = 1'b0; miss_valid = 1'b0;
    chk("R9 wake includes late thread", wake_threads, 4'b0011);
    step(); step();
    chk("R9 no new request", fill_req_valid, 0);
    chk("R9 no slot held", full, 0);
    miss(LJ, 2'd2, 1'b0);
    serve("R9 R11 slot 0 free", 2'd0, LJ, 1'b0);
    fill(2'd0);
    chk("R7 wake single", wake_threads, 4'b0100);

    // R6 round robin, R10 full, R11 reuse of lowest slot
    miss(LC, 2'd0, 1'b0);
    miss(LD, 2'd1, 1'b0);
    miss(LE, 2'd2, 1'b0);
    serve("R6 first", 2'd0, LC, 1'b0);
    step();
    chk("R6 next is slot1", fill_req_slot, 1);
    fill(2'd0);
    chk("R6 wake slot0", wake_threads, 4'b0001);
    miss(LG, 2'd3, 1'b0);
    serve("R6 slot1", 2'd1, LD, 1'b0);
    serve("R6 slot2 before slot0", 2'd2, LE, 1'b0);
    serve("R6 R11 wrap to slot0", 2'd0, LG, 1'b0);
    miss(LK, 2'd0, 1'b0);
    chk("R10 full", full, 1);
    serve("R10 last slot", 2'd3, LK, 1'b0);
    fill(2'd1);
    chk("R8 wake slot1", wake_threads, 4'b0010);
    chk("R10 not full", full, 0);
    fill(2'd2);
    chk("R8 wake slot2", wake_threads, 4'b0100);
    fill(2'd0);
    chk("R8 wake slot0", wake_threads, 4'b1000);
    fill(2'd3);
    chk("R8 wake slot3", wake_threads, 4'b0001);
    step();
    chk("R1 idle again", wake_threads, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule